// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synchronous static RAM with 32-bit words and a burst address generator. Every address, control and write-data input is captured on the rising clock edge. A burst can be opened by either of two start strobes. The processor-side strobe always opens a read. The controller-side strobe opens a write or a read, depending on the write inputs. While no strobe is active, an advance input either steps the 2-bit burst counter or holds the current address. The step order is interleaved (XOR of the start offset with the count) or linear (the count added modulo 4), chosen by a level input.

Three chip selects of mixed polarity qualify each burst start. Writes can cover all byte lanes at once or individual lanes. Read data passes through two register stages before it reaches the bus. A registered enable travels alongside the read data and drives the bus enable, so a deselect releases the bus with the same latency as read data. An asynchronous output-enable input and a sleep input can also force the bus off. After sleep, the block ignores its inputs for a fixed wake-up period.

The block has no data handshake. It accepts one command on every clock edge and never applies back-pressure. A reader must take the data in the cycle it appears on the bus, two edges after the address. The bidirectional bus is split into an input, an output and an output-enable port. Depth is set by the address width parameter.

Top module: `sync_burst_sram`

## Requirements
- R1: A word has four 8-bit lanes. Lane k occupies bits 8k+7:8k of `dq_i`/`dq_o` and is controlled by `lane_n[k]`. The array holds 2^ADDR_W words, and every word can be written and read back.
- R2: The device counts as selected only when `cs_a_n`=0, `cs_b`=1 and `cs_c_n`=0. A strobe that acts while the device is not selected ends the burst, and `dq_oe` is low two edges later.
- R3: While `cs_a_n`=1, `start_cpu_n` has no effect. With `start_ctl_n` also high, the edge acts as a burst continuation. With `start_ctl_n` low, R2 or R5 applies.
- R4: When `start_cpu_n`=0, `cs_a_n`=0 and the device is selected, a read burst opens at `addr`. The write inputs have no effect on that edge.
- R5: When `start_ctl_n`=0, `start_cpu_n`=1 and the device is selected, a burst opens at `addr`. It writes on that edge if R8 enables any lane, and reads otherwise.
- R6: With both strobes high and a burst open, `step_n`=0 moves to the next burst address and `step_n`=1 repeats the current one. On either, the access reads or writes under R8 (lanes from `dq_i`).
- R7: The burst address keeps the upper bits of the start address. Its two low bits are start^k when `seq_linear`=0, and (start+k) mod 4 when `seq_linear`=1, where k is the step count 0..3 and wraps.
- R8: `wr_all_n`=0 enables all lanes. Otherwise lane k is enabled when `wr_byte_n`=0 and `lane_n[k]`=0. An access with no lane enabled is a read.
- R9: For a read whose address is taken at edge N, `dq_o` holds the word and `dq_oe` is high after edge N+1, unless R10 or R11 forces the bus off.
- R10: `out_en_n`=1 forces `dq_oe` low at once, without waiting for a clock edge.
- R11: `doze`=1 forces `dq_oe` low, closes the burst and makes every edge a no-op. After `doze` falls, the next three edges are no-ops and the fourth edge is acted on.
- R12: After reset, `dq_oe` is low and no burst is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset of control state |
| addr | input | ADDR_W | Burst start address |
| cs_a_n | input | 1 | Chip select, active low; also gates the processor strobe |
| cs_b | input | 1 | Chip select, active high |
| cs_c_n | input | 1 | Chip select, active low |
| start_cpu_n | input | 1 | Processor burst start, active low, always a read |
| start_ctl_n | input | 1 | Controller burst start, active low |
| step_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_byte_n | input | 1 | Per-lane write qualifier, active low |
| lane_n | input | 4 | Per-lane write enables, active low |
| out_en_n | input | 1 | Asynchronous bus enable, active low |
| doze | input | 1 | Sleep request, active high |
| seq_linear | input | 1 | 1 selects linear order, 0 interleaved |
| dq_i | input | 32 | Write data from the bus |
| dq_o | output | 32 | Read data to the bus |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The wake-up window after sleep is the hardest state to reach from the ports. The bench has to raise `doze`, drop it, and then present a valid burst start on each of the following edges, so that it can see that exactly the first three starts are lost. A directed sequence does this. Random stimulus also pulses `doze` now and then in the middle of bursts. A second hard case is a processor strobe hidden by `cs_a_n` in the middle of a burst, where the strobe must not restart the burst. The bench covers it with a directed case, and random chip-select patterns add further instances.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
  // control decoded from one clock edge
  typedef struct packed {
    logic load;     // open a burst at the external address
    logic step;     // advance the burst count
    logic access;   // an array access happens this edge
    logic is_write; // that access writes
    logic drop;     // burst closed by a deselect
  } op_ctl_t;

  function automatic logic [1:0] burst_low(logic [1:0] start, logic [1:0] k, logic linear);
    return linear ? 2'(start + k) : (start ^ k);
  endfunction
endpackage

// File: rtl/sbsram_decode.sv
module sbsram_decode
  import sbsram_pkg::*;
(
  input  logic    cs_a_n,
  input  logic    cs_b,
  input  logic    cs_c_n,
  input  logic    start_cpu_n,
  input  logic    start_ctl_n,
  input  logic    step_n,
  input  logic    wreq,
  input  logic    active,
  output op_ctl_t op
);
  logic selected, cpu_go, strobe_hit;

  assign selected   = !cs_a_n && cs_b && !cs_c_n;
  assign cpu_go     = !start_cpu_n && !cs_a_n;
  assign strobe_hit = cpu_go || !start_ctl_n;

  always_comb begin
    op = '0;
    if (strobe_hit) begin
      if (selected) begin
        op.load     = 1'b1;
        op.access   = 1'b1;
        op.is_write = cpu_go ? 1'b0 : wreq;
      end else begin
        op.drop = 1'b1;
      end
    end else if (active) begin
      op.access   = 1'b1;
      op.step     = !step_n;
      op.is_write = wreq;
    end
  end
endmodule

// File: rtl/sbsram_lanes.sv
module sbsram_lanes #(
  parameter int LANES = 4
) (
  input  logic             wr_all_n,
  input  logic             wr_byte_n,
  input  logic [LANES-1:0] lane_n,
  output logic [LANES-1:0] lane_sel
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_sel[i] = !wr_all_n || (!wr_byte_n && !lane_n[i]);
  end
endmodule

// File: rtl/sbsram_burst.sv
module sbsram_burst
  import sbsram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  op_ctl_t           op,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              linear,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              active
);
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q, cnt_nx;
  logic              act_q;

  assign cnt_nx   = op.step ? 2'(cnt_q + 2'd1) : cnt_q;
  assign acc_addr = op.load ? ext_addr
                            : {base_q[ADDR_W-1:2], burst_low(base_q[1:0], cnt_nx, linear)};
  assign active   = act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
    end else if (!en) begin
      act_q <= 1'b0;
    end else if (op.load) begin
      base_q <= ext_addr;
      cnt_q  <= '0;
      act_q  <= 1'b1;
    end else if (op.drop) begin
      act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nx;
    end
  end
endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        we,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];
    always_ff @(posedge clk) begin
      if (we[i]) store[waddr] <= wdata[i*LANE_W +: LANE_W];
      rdata[i*LANE_W +: LANE_W] <= store[raddr];
    end
  end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbsram_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int LANES       = 4,
  parameter int LANE_W      = 8,
  parameter int WAKE_CYCLES = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    cs_a_n,
  input  logic                    cs_b,
  input  logic                    cs_c_n,
  input  logic                    start_cpu_n,
  input  logic                    start_ctl_n,
  input  logic                    step_n,
  input  logic                    wr_all_n,
  input  logic                    wr_byte_n,
  input  logic [LANES-1:0]        lane_n,
  input  logic                    out_en_n,
  input  logic                    doze,
  input  logic                    seq_linear,
  input  logic [LANES*LANE_W-1:0] dq_i,
  output logic [LANES*LANE_W-1:0] dq_o,
  output logic                    dq_oe
);
  localparam int WAKE_W = $clog2(WAKE_CYCLES + 1);

  logic [WAKE_W-1:0] wake_q;
  logic              awake;
  logic [LANES-1:0]  lane_sel, we;
  logic              wreq, active;
  op_ctl_t           op;
  logic [ADDR_W-1:0] acc_addr, rd_a_q;
  logic              rd_v_q, oe_q;

  assign awake = (wake_q == '0) && !doze;
  assign wreq  = |lane_sel;

  sbsram_lanes #(.LANES(LANES)) u_lanes (
    .wr_all_n (wr_all_n),
    .wr_byte_n(wr_byte_n),
    .lane_n   (lane_n),
    .lane_sel (lane_sel)
  );

  sbsram_decode u_dec (
    .cs_a_n     (cs_a_n),
    .cs_b       (cs_b),
    .cs_c_n     (cs_c_n),
    .start_cpu_n(start_cpu_n),
    .start_ctl_n(start_ctl_n),
    .step_n     (step_n),
    .wreq       (wreq),
    .active     (active),
    .op         (op)
  );

  sbsram_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (awake),
    .op      (op),
    .ext_addr(addr),
    .linear  (seq_linear),
    .acc_addr(acc_addr),
    .active  (active)
  );

  assign we = (awake && op.access && op.is_write) ? lane_sel : '0;

  sbsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk  (clk),
    .we   (we),
    .waddr(acc_addr),
    .wdata(dq_i),
    .raddr(rd_a_q),
    .rdata(dq_o)
  );

  // wake-up timer
  always_ff @(posedge clk) begin
    if (!rst_n)              wake_q <= '0;
    else if (doze)           wake_q <= WAKE_W'(WAKE_CYCLES);
    else if (wake_q != '0)   wake_q <= wake_q - 1'b1;
  end

  // read pipeline: address stage then output stage with matched enable
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_v_q <= 1'b0;
      rd_a_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      rd_v_q <= awake && op.access && !op.is_write;
      rd_a_q <= acc_addr;
      oe_q   <= rd_v_q;
    end
  end

  assign dq_oe = oe_q && !out_en_n && !doze;
endmodule

// File: rtl/sbsram_props.sv
module sbsram_props (
  input logic clk,
  input logic rst_n,
  input logic awake,
  input logic cs_a_n,
  input logic cs_b,
  input logic cs_c_n,
  input logic start_cpu_n,
  input logic start_ctl_n,
  input logic wr_all_n,
  input logic out_en_n,
  input logic doze,
  input logic dq_oe
);
  logic sel;
  assign sel = !cs_a_n && cs_b && !cs_c_n;

  p_read_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (awake && sel && !start_cpu_n) |=> ##1 (out_en_n || doze || dq_oe));

  p_deselect_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (awake && !sel && ((!start_cpu_n && !cs_a_n) || !start_ctl_n)) |=> ##1 !dq_oe);

  p_ctl_write_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (awake && sel && start_cpu_n && !start_ctl_n && !wr_all_n) |=> ##1 !dq_oe);

  p_asleep_start_lost_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!awake && start_ctl_n) |=> ##1 !dq_oe);

  p_reset_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !dq_oe);
endmodule

bind sync_burst_sram sbsram_props u_props (
  .clk        (clk),
  .rst_n      (rst_n),
  .awake      (awake),
  .cs_a_n     (cs_a_n),
  .cs_b       (cs_b),
  .cs_c_n     (cs_c_n),
  .start_cpu_n(start_cpu_n),
  .start_ctl_n(start_ctl_n),
  .wr_all_n   (wr_all_n),
  .out_en_n   (out_en_n),
  .doze       (doze),
  .dq_oe      (dq_oe)
);

// File: tb/sim_sync_burst_sram.sv
`timescale 1ns/1ps
module sim_sync_burst_sram;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic cs_a_n = 1'b0, cs_b = 1'b1, cs_c_n = 1'b0;
  logic start_cpu_n = 1'b1, start_ctl_n = 1'b1, step_n = 1'b1;
  logic wr_all_n = 1'b1, wr_byte_n = 1'b1;
  logic [3:0] lane_n = 4'hF;
  logic out_en_n = 1'b0, doze = 1'b0, seq_linear = 1'b0;
  logic [31:0] dq_i = '0;
  logic [31:0] dq_o;
  logic dq_oe;

  always #2 clk = ~clk;

  sync_burst_sram u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .cs_a_n(cs_a_n), .cs_b(cs_b), .cs_c_n(cs_c_n),
    .start_cpu_n(start_cpu_n), .start_ctl_n(start_ctl_n), .step_n(step_n),
    .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_n(lane_n), .out_en_n(out_en_n),
    .doze(doze), .seq_linear(seq_linear), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
  );

  int vectors = 0, fails = 0;
  bit done = 0;
  string focus = "R12";

  // reference model state
  logic [31:0] mmem [DEPTH];
  logic [AW-1:0] m_base = '0, m_a1 = '0;
  logic [1:0] m_cnt = '0;
  logic m_act = 0, m_v1 = 0, m_oe = 0;
  logic [31:0] m_q = '0;
  int m_wake = 0;
  string m_tag1 = "R12", m_tag2 = "R12";

  function automatic logic [AW-1:0] burst_at(logic [AW-1:0] b, logic [1:0] k, logic lin);
    logic [1:0] lo;
    lo = lin ? 2'((b[1:0] + k) & 2'b11) : (b[1:0] ^ k);
    return {b[AW-1:2], lo};
  endfunction

  function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] nw, logic [3:0] m);
    logic [31:0] r = old;
    for (int k = 0; k < 4; k++) if (m[k]) r[8*k +: 8] = nw[8*k +: 8];
    return r;
  endfunction

  task automatic model_edge();
    logic awk, sel, cpu, hit, acc, wr;
    logic [3:0] lanes;
    logic [AW-1:0] a;
    string tg;
    m_oe = m_v1; m_q = mmem[m_a1]; m_tag2 = m_tag1;
    awk = (m_wake == 0) && !doze;
    if (doze) m_wake = 3; else if (m_wake != 0) m_wake--;
    if (!awk) begin
      m_act = 0; m_v1 = 0; m_tag1 = "R11";
      return;
    end
    sel = !cs_a_n && cs_b && !cs_c_n;
    cpu = !start_cpu_n && !cs_a_n;
    hit = cpu || !start_ctl_n;
    for (int k = 0; k < 4; k++) lanes[k] = !wr_all_n || (!wr_byte_n && !lane_n[k]);
    acc = 0; wr = 0; a = m_a1; tg = "R2";
    if (hit) begin
      if (sel) begin
        m_base = addr; m_cnt = 0; m_act = 1; acc = 1; a = addr;
        wr = cpu ? 1'b0 : (lanes != 0);
        tg = cpu ? "R4" : "R5";
      end else m_act = 0;
    end else if (m_act) begin
      if (!step_n) m_cnt = m_cnt + 2'd1;
      a = burst_at(m_base, m_cnt, seq_linear);
      acc = 1; wr = (lanes != 0); tg = "R6";
    end
    if (acc && wr) mmem[a] = merge(mmem[a], dq_i, lanes);
    m_v1 = acc && !wr; m_a1 = a; m_tag1 = tg;
  endtask

  task automatic cyc();
    logic eo;
    string tg;
    @(posedge clk); #1;
    if (!rst_n) begin
      m_act = 0; m_v1 = 0; m_oe = 0; m_wake = 0; m_cnt = 0; m_base = '0; m_a1 = '0;
      m_tag1 = "R12"; m_tag2 = "R12";
    end else model_edge();
    @(negedge clk);
    eo = m_oe && !out_en_n && !doze;
    tg = doze ? "R11" : (out_en_n ? "R10" : m_tag2);
    vectors++;
    if (dq_oe !== eo) begin
      fails++;
      $display("FAIL %s/%s dq_oe actual %b expected %b", focus, tg, dq_oe, eo);
    end
    if (eo) begin
      vectors++; // R9: data for address taken two edges back
      if (dq_o !== m_q) begin
        fails++;
        $display("FAIL %s/%s/R9 dq_o actual %h expected %h", focus, tg, dq_o, m_q);
      end
    end
  endtask

  task automatic idle();
    cs_a_n = 0; cs_b = 1; cs_c_n = 0; start_cpu_n = 1; start_ctl_n = 1; step_n = 1;
    wr_all_n = 1; wr_byte_n = 1; lane_n = 4'hF; out_en_n = 0; doze = 0;
  endtask

  task automatic cpu_read(logic [AW-1:0] a);
    idle(); addr = a; start_cpu_n = 0; cyc(); idle();
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < DEPTH; i++) mmem[i] = '0;
    idle();
    repeat (3) cyc();
    rst_n = 1;
    focus = "R12";
    cyc(); cyc();

    // R1 and R7 linear: fill every word with global-write bursts
    focus = "R1";
    seq_linear = 1;
    for (int b = 0; b < DEPTH; b += 4) begin
      idle(); addr = AW'(b + (b/4)%4); start_ctl_n = 0; wr_all_n = 0; dq_i = $urandom; cyc();
      for (int k = 0; k < 3; k++) begin
        idle(); wr_all_n = 0; step_n = 0; dq_i = $urandom; cyc();
      end
    end
    // R1: read back every word (single reads, cpu strobe)
    for (int b = 0; b < DEPTH; b++) cpu_read(AW'(b));
    cyc(); cyc();

    // R7 interleaved read bursts from every offset
    focus = "R7";
    seq_linear = 0;
    for (int s = 0; s < 4; s++) begin
      cpu_read(AW'(40 + s));
      for (int k = 0; k < 4; k++) begin idle(); step_n = 0; cyc(); end
    end
    // R6 suspend: step_n high keeps the address
    focus = "R6";
    cpu_read(AW'(81));
    repeat (3) cyc();
    idle(); step_n = 0; cyc(); idle(); cyc();
    // R6 write after processor read on the next edge, same address
    idle(); wr_all_n = 0; dq_i = 32'hCAFE_0001; cyc(); idle(); cyc(); cyc();

    // R8 byte lanes
    focus = "R8";
    idle(); addr = 10'd200; start_ctl_n = 0; wr_byte_n = 0; lane_n = 4'b1010; dq_i = 32'h1122_3344; cyc();
    cpu_read(10'd200); cyc(); cyc();
    idle(); addr = 10'd200; start_ctl_n = 0; wr_byte_n = 1; lane_n = 4'b0000; dq_i = 32'hFFFF_FFFF; cyc();
    cyc(); cyc(); // R8: no lane enabled -> read, old data expected
    idle(); addr = 10'd201; start_ctl_n = 0; wr_byte_n = 0; lane_n = 4'b0111; wr_all_n = 0; dq_i = 32'hA5A5_5A5A; cyc();
    cpu_read(10'd201); cyc(); cyc();

    // R4: write inputs ignored on processor start
    focus = "R4";
    idle(); addr = 10'd300; start_cpu_n = 0; wr_all_n = 0; dq_i = 32'hDEAD_BEEF; cyc();
    idle(); cyc(); cyc();

    // R3: processor strobe hidden by cs_a_n mid-burst
    focus = "R3";
    cpu_read(10'd400);
    idle(); cs_a_n = 1; start_cpu_n = 0; addr = 10'd7; step_n = 0; cyc();
    idle(); cyc(); cyc();

    // R2: deselect by cs_b low with controller strobe
    focus = "R2";
    cpu_read(10'd500);
    idle(); cs_b = 0; start_ctl_n = 0; cyc();
    idle(); cyc(); cyc(); cyc();
    idle(); cs_c_n = 1; start_cpu_n = 0; cyc(); idle(); cyc(); cyc();

    // R10: asynchronous output disable
    focus = "R10";
    cpu_read(10'd600);
    idle(); out_en_n = 1; cyc(); cyc();
    idle(); cyc();

    // R11: sleep, then a start on each edge of the wake window
    focus = "R11";
    cpu_read(10'd700);
    idle(); doze = 1; cyc(); cyc(); cyc();
    for (int k = 0; k < 5; k++) begin
      idle(); addr = AW'(710 + k); start_cpu_n = 0; cyc();
    end
    idle(); cyc(); cyc();

    // R5/R9 and general mix: constrained random
    focus = "R9";
    for (int n = 0; n < 4000; n++) begin
      cs_a_n = ($urandom % 8) == 0; cs_b = ($urandom % 8) != 0; cs_c_n = ($urandom % 8) == 0;
      start_cpu_n = ($urandom % 4) != 0; start_ctl_n = ($urandom % 4) != 0;
      step_n = $urandom % 2; wr_all_n = ($urandom % 4) != 0; wr_byte_n = $urandom % 2;
      lane_n = 4'($urandom); out_en_n = ($urandom % 8) == 0; doze = ($urandom % 40) == 0;
      seq_linear = $urandom % 2; addr = AW'($urandom); dq_i = $urandom;
      cyc();
    end
    // R5 read branch: controller start without write request
    focus = "R5";
    idle(); addr = 10'd900; start_ctl_n = 0; cyc(); idle(); cyc(); cyc();

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule